// File: doc/BRIEF.md
# Real-time clock control registers and address bank switch

This unit is the control and status section of a nibble-wide real-time clock. A one-second carry is derived from a fast timebase tick. Around each carry, the unit raises a busy flag that shuts off writes to the time/calendar counters. It also keeps a power-on flag, a self-clearing system-reset bit, a stored test bit and a two-bit address-mode field.

A parallel nibble port (address, write strobe, write data, read data) reaches the unit. The address-mode field switches the 4-bit address space between three maps. The first holds the clock counters and the control registers. The second holds the lower half of a 120-nibble user RAM, and the third holds the upper half. The mode field's own register stays reachable in every map. The counters, the first control register and the RAM live outside the unit. The unit drives their selects, their write enables, a RAM index and a counter-clear level. When one of those targets is addressed, it passes their read data through.

Top module: `rtc_ctrl_bank`

## Requirements
- R1: After reset, the following are all 0: busy, carry, counter clear, power-on flag, system-reset bit, test bit and mode field. Reading address 15 then returns 0000.
- R2: `carry_o` pulses for exactly one cycle. It comes in the cycle after every TICKS_PER_SEC-th `tick_i`, counted from reset.
- R3: Let n be the number of ticks since reset. After tick n, `busy_o` is 1 when n mod TICKS_PER_SEC ≥ TICKS_PER_SEC−BUSY_LEAD, and also when n>0 with n mod TICKS_PER_SEC = 0. It is 0 otherwise. Therefore the flag rises BUSY_LEAD ticks before the carry, covers the carry cycle, and falls on the next tick.
- R4: `cnt_we_o` is `wr_i` gated by the counter select and by a low `busy_o`. A counter write made while busy gives no enable.
- R5: A `por_i` pulse sets the power-on flag. A write to address 15 with bit 3 = 1 clears it. If both occur in the same cycle, the pulse wins.
- R6: Writing address 15 stores bit 3 as the system-reset bit, bit 2 as the test bit, and bits 1:0 as the mode field. Reading address 15 returns that same layout in every mode.
- R7: `cnt_clr_o` follows the system-reset bit. The bit clears in a cycle where `cs_i`=1, `sck_i`=0 and no write to address 15 occurs. A write in the same cycle wins.
- R8: In mode 0, reading address 14 returns {busy, power-on flag, 0, 0}. Writes to address 14 change neither flag.
- R9: Mode field 00 or 01 selects map 0. In map 0, addresses 0–12 select the counters and addresses 13–15 select the control registers.
- R10: Mode field 10 gives map 1 and 11 gives map 2. In both, address 15 selects the control registers. Addresses 0–14 select the RAM, with `ram_idx_o` = address (map 1) or address+60 (map 2), and `ram_we_o` = `wr_i`.
- R11: Exactly one of the three selects is high at all times. Reads of any address other than 14 in map 0 or 15 return `ext_rdata_i`. When the RAM is not selected, `ram_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Fast timebase tick, one-cycle pulse |
| por_i | input | 1 | Power-on-clear detect pulse |
| cs_i | input | 1 | Chip-select level |
| sck_i | input | 1 | Serial clock level |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write nibble |
| ext_rdata_i | input | 4 | Read nibble from counters, first control register or RAM |
| rdata_o | output | 4 | Read nibble |
| busy_o | output | 1 | Carry window flag |
| carry_o | output | 1 | One-second carry pulse to counters |
| cnt_clr_o | output | 1 | Hold-clear for time/calendar counters |
| sel_cnt_o | output | 1 | Counter bank selected |
| sel_ctl_o | output | 1 | Control registers selected |
| sel_ram_o | output | 1 | User RAM selected |
| cnt_we_o | output | 1 | Counter write enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_idx_o | output | 7 | RAM nibble index 0–119 |

## Verification
A counter write can land in the very cycle whose tick raises the busy flag. The bench holds a counter write on every tick of a 20-tick sweep, using a small configuration of 8 ticks per second and a lead of 2. It checks that the enable is still granted before the rising edge and withdrawn right after it. A second collision is set up in the same cycle, by hand: a system-reset write alongside a power-on pulse, and also alongside the chip-select/clock release condition. The expected results are that the flag stays set and that the reset bit survives one cycle.

// File: rtl/rtc_ctl_pkg.sv
`timescale 1ns/1ps
// Shared constants and the map type for the clock control unit.
// Assumes a fixed 4-bit address and 4-bit data path.
package rtc_ctl_pkg;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;

    // Control register addresses (the decode depends on these positions)
    localparam logic [ADDR_W-1:0] A_CTL1 = 4'hD;
    localparam logic [ADDR_W-1:0] A_STAT = 4'hE;
    localparam logic [ADDR_W-1:0] A_MODE = 4'hF;

    // Bit positions inside the status and mode registers
    localparam int B_BUSY = 3;
    localparam int B_PON  = 2;
    localparam int B_SRST = 3;
    localparam int B_TEST = 2;

    typedef enum logic [1:0] {
        MAP_CLOCK  = 2'd0,
        MAP_RAM_LO = 2'd1,
        MAP_RAM_HI = 2'd2
    } map_mode_e;

    // Translate the stored 2-bit mode field into a map.
    function automatic map_mode_e map_from_field(input logic [1:0] f);
        if (!f[1])     return MAP_CLOCK;
        else if (!f[0]) return MAP_RAM_LO;
        else            return MAP_RAM_HI;
    endfunction
endpackage

// File: rtl/rtc_carry_timer.sv
`timescale 1ns/1ps
// Divides the timebase tick into a one-second carry and produces the
// busy window around it. Assumes 1 <= LEAD < TPS and tick_i is a pulse.
module rtc_carry_timer #(
    parameter int TPS  = 4096,
    parameter int LEAD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic carry_o,
    output logic busy_o
);
    localparam int CW    = (TPS > 1) ? $clog2(TPS) : 1;
    localparam int START = TPS - LEAD;

    logic [CW-1:0] sub_q;
    logic [CW-1:0] sub_nxt;
    logic          wrap;
    logic          carry_q;
    logic          busy_q;

    // Next value of the sub-second count and the wrap condition.
    always_comb begin
        wrap    = (sub_q == CW'(TPS - 1));
        sub_nxt = wrap ? '0 : sub_q + 1'b1;
    end

    // Sub-second counter advancing on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      sub_q <= '0;
        else if (tick_i) sub_q <= sub_nxt;
    end

    // One-cycle carry pulse registered on the wrapping tick.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= tick_i && wrap;
    end

    // Busy window: set LEAD ticks ahead, kept through the wrap, dropped next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (tick_i) busy_q <= (sub_nxt >= CW'(START)) || wrap;
    end

    assign carry_o = carry_q;
    assign busy_o  = busy_q;
endmodule

// File: rtl/rtc_addr_map.sv
`timescale 1ns/1ps
// Decodes address and map into target selects, write enables and the
// RAM index. Purely combinational; assumes RAM_HALF fits the index width.
module rtc_addr_map
    import rtc_ctl_pkg::*;
#(
    parameter int RAM_HALF  = 60,
    parameter int IDX_W     = 7
) (
    input  map_mode_e         map_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              busy_i,
    output logic              sel_cnt_o,
    output logic              sel_ctl_o,
    output logic              sel_ram_o,
    output logic              cnt_we_o,
    output logic              ram_we_o,
    output logic              hit_stat_o,
    output logic              hit_mode_o,
    output logic [IDX_W-1:0]  ram_idx_o
);
    // Target select and RAM index per map.
    always_comb begin
        sel_cnt_o = 1'b0;
        sel_ctl_o = 1'b0;
        sel_ram_o = 1'b0;
        ram_idx_o = '0;
        if (map_i == MAP_CLOCK) begin
            if (addr_i >= A_CTL1) sel_ctl_o = 1'b1;
            else                  sel_cnt_o = 1'b1;
        end else begin
            if (addr_i == A_MODE) begin
                sel_ctl_o = 1'b1;
            end else begin
                sel_ram_o = 1'b1;
                ram_idx_o = IDX_W'(addr_i)
                          + ((map_i == MAP_RAM_HI) ? IDX_W'(RAM_HALF) : IDX_W'(0));
            end
        end
    end

    // Internal register hits: status only in the clock map, mode everywhere.
    always_comb begin
        hit_stat_o = (map_i == MAP_CLOCK) && (addr_i == A_STAT);
        hit_mode_o = (addr_i == A_MODE);
    end

    // Write enables; the carry window blocks counter writes.
    always_comb begin
        cnt_we_o = wr_i && sel_cnt_o && !busy_i;
        ram_we_o = wr_i && sel_ram_o;
    end
endmodule

// File: rtl/rtc_ctl_regs.sv
`timescale 1ns/1ps
// Holds the power-on flag, system-reset bit, test bit and mode field and
// builds the read nibble. Assumes por_i and write strobes are one cycle.
module rtc_ctl_regs
    import rtc_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_i,
    input  logic             cs_i,
    input  logic             sck_i,
    input  logic             wr_i,
    input  logic             hit_stat_i,
    input  logic             hit_mode_i,
    input  logic [NIB_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic [NIB_W-1:0] ext_rdata_i,
    output logic             pon_o,
    output logic             srst_o,
    output logic [1:0]       field_o,
    output logic [NIB_W-1:0] rdata_o
);
    logic       pon_q;
    logic       srst_q;
    logic       test_q;
    logic [1:0] field_q;
    logic       mode_wr;
    logic       srst_wr;
    logic       release_hit;

    // Write and release qualifiers.
    always_comb begin
        mode_wr     = wr_i && hit_mode_i;
        srst_wr     = mode_wr && wdata_i[B_SRST];
        release_hit = cs_i && !sck_i;
    end

    // Power-on flag: detection wins over the clear from a reset write.
    always_ff @(posedge clk) begin
        if (!rst_n)       pon_q <= 1'b0;
        else if (por_i)   pon_q <= 1'b1;
        else if (srst_wr) pon_q <= 1'b0;
    end

    // System-reset bit: a write wins over the self-clear condition.
    always_ff @(posedge clk) begin
        if (!rst_n)           srst_q <= 1'b0;
        else if (mode_wr)     srst_q <= wdata_i[B_SRST];
        else if (release_hit) srst_q <= 1'b0;
    end

    // Test bit and map field are plain stored values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q  <= 1'b0;
            field_q <= 2'b00;
        end else if (mode_wr) begin
            test_q  <= wdata_i[B_TEST];
            field_q <= wdata_i[1:0];
        end
    end

    // Read nibble: internal registers first, otherwise external data.
    always_comb begin
        if (hit_mode_i)      rdata_o = {srst_q, test_q, field_q};
        else if (hit_stat_i) rdata_o = {busy_i, pon_q, 2'b00};
        else                 rdata_o = ext_rdata_i;
    end

    assign pon_o   = pon_q;
    assign srst_o  = srst_q;
    assign field_o = field_q;
endmodule

// File: rtl/rtc_ctrl_bank.sv
`timescale 1ns/1ps
// Top of the clock control unit: carry timer, register file and address
// map. Assumes synchronous inputs; cs_i/sck_i are already synchronised.
module rtc_ctrl_bank
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4096,
    parameter int BUSY_LEAD     = 16,
    parameter int RAM_HALF      = 60
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_i,
    input  logic                            por_i,
    input  logic                            cs_i,
    input  logic                            sck_i,
    input  logic [3:0]                      addr_i,
    input  logic                            wr_i,
    input  logic [3:0]                      wdata_i,
    input  logic [3:0]                      ext_rdata_i,
    output logic [3:0]                      rdata_o,
    output logic                            busy_o,
    output logic                            carry_o,
    output logic                            cnt_clr_o,
    output logic                            sel_cnt_o,
    output logic                            sel_ctl_o,
    output logic                            sel_ram_o,
    output logic                            cnt_we_o,
    output logic                            ram_we_o,
    output logic [$clog2(2*RAM_HALF)-1:0]   ram_idx_o
);
    localparam int IDX_W = $clog2(2*RAM_HALF);

    logic       busy_w;
    logic       pon_w;
    logic       srst_w;
    logic [1:0] field_w;
    logic       hit_stat;
    logic       hit_mode;
    map_mode_e  map_w;

    // Map selection from the stored field.
    always_comb map_w = map_from_field(field_w);

    rtc_carry_timer #(
        .TPS  (TICKS_PER_SEC),
        .LEAD (BUSY_LEAD)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .carry_o (carry_o),
        .busy_o  (busy_w)
    );

    rtc_addr_map #(
        .RAM_HALF (RAM_HALF),
        .IDX_W    (IDX_W)
    ) map_i (
        .map_i      (map_w),
        .addr_i     (addr_i),
        .wr_i       (wr_i),
        .busy_i     (busy_w),
        .sel_cnt_o  (sel_cnt_o),
        .sel_ctl_o  (sel_ctl_o),
        .sel_ram_o  (sel_ram_o),
        .cnt_we_o   (cnt_we_o),
        .ram_we_o   (ram_we_o),
        .hit_stat_o (hit_stat),
        .hit_mode_o (hit_mode),
        .ram_idx_o  (ram_idx_o)
    );

    rtc_ctl_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_i       (por_i),
        .cs_i        (cs_i),
        .sck_i       (sck_i),
        .wr_i        (wr_i),
        .hit_stat_i  (hit_stat),
        .hit_mode_i  (hit_mode),
        .wdata_i     (wdata_i),
        .busy_i      (busy_w),
        .ext_rdata_i (ext_rdata_i),
        .pon_o       (pon_w),
        .srst_o      (srst_w),
        .field_o     (field_w),
        .rdata_o     (rdata_o)
    );

    assign busy_o    = busy_w;
    assign cnt_clr_o = srst_w;
endmodule

// File: rtl/rtc_ctrl_bank_chk.sv
`timescale 1ns/1ps
// Property checker for rtc_ctrl_bank, attached by bind below.
// Assumes the parameters match the bound instance.
module rtc_ctrl_bank_chk #(
    parameter int TICKS_PER_SEC = 4096,
    parameter int BUSY_LEAD     = 16,
    parameter int RAM_HALF      = 60,
    parameter int IDX_W         = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             por_i,
    input logic             cs_i,
    input logic             sck_i,
    input logic             wr_i,
    input logic [3:0]       addr_i,
    input logic             srst_bit_i,
    input logic             busy_o,
    input logic             carry_o,
    input logic             cnt_we_o,
    input logic             sel_cnt_o,
    input logic             sel_ctl_o,
    input logic             sel_ram_o,
    input logic [IDX_W-1:0] ram_idx_o,
    input logic             pon_q,
    input logic             srst_q
);
    localparam int LW = $clog2(TICKS_PER_SEC + 1);

    logic [LW-1:0] lead_cnt;
    logic          mode_wr;

    // Ticks seen while the busy window was open.
    always_ff @(posedge clk) begin
        if (!rst_n)       lead_cnt <= '0;
        else if (!busy_o) lead_cnt <= '0;
        else if (tick_i)  lead_cnt <= lead_cnt + 1'b1;
    end

    // Write to the mode register in this cycle.
    always_comb mode_wr = wr_i && (addr_i == 4'hF);

    a_r2_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> !carry_o);
    a_r3_carry_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> busy_o);
    a_r3_lead_length: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (lead_cnt == LW'(BUSY_LEAD)));
    a_r4_no_counter_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cnt_we_o);
    a_r5_por_sets: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> pon_q);
    a_r5_reset_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && srst_bit_i && !por_i) |=> !pon_q);
    a_r7_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && srst_bit_i) |=> srst_q);
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && cs_i && !sck_i && !mode_wr) |=> !srst_q);
    a_r10_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram_o |-> (ram_idx_o < IDX_W'(2*RAM_HALF)));
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_cnt_o, sel_ctl_o, sel_ram_o}) == 1);
endmodule

bind rtc_ctrl_bank rtc_ctrl_bank_chk #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .BUSY_LEAD     (BUSY_LEAD),
    .RAM_HALF      (RAM_HALF),
    .IDX_W         ($clog2(2*RAM_HALF))
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .por_i      (por_i),
    .cs_i       (cs_i),
    .sck_i      (sck_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .srst_bit_i (wdata_i[3]),
    .busy_o     (busy_o),
    .carry_o    (carry_o),
    .cnt_we_o   (cnt_we_o),
    .sel_cnt_o  (sel_cnt_o),
    .sel_ctl_o  (sel_ctl_o),
    .sel_ram_o  (sel_ram_o),
    .ram_idx_o  (ram_idx_o),
    .pon_q      (pon_w),
    .srst_q     (srst_w)
);

// File: tb/rtc_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: decode sweep over all maps and addresses, a tick
// sweep over the carry window, and hand-built flag collisions.
module rtc_ctrl_bank_tb_top;
    localparam int TPS  = 8;
    localparam int LEAD = 2;
    localparam int HALF = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       por_i = 1'b0;
    logic       cs_i = 1'b0;
    logic       sck_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic       wr_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic [3:0] ext_rdata_i = '0;
    logic [3:0] rdata_o;
    logic       busy_o, carry_o, cnt_clr_o;
    logic       sel_cnt_o, sel_ctl_o, sel_ram_o, cnt_we_o, ram_we_o;
    logic [6:0] ram_idx_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_ctrl_bank #(
        .TICKS_PER_SEC (TPS),
        .BUSY_LEAD     (LEAD),
        .RAM_HALF      (HALF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .por_i (por_i),
        .cs_i (cs_i), .sck_i (sck_i), .addr_i (addr_i), .wr_i (wr_i),
        .wdata_i (wdata_i), .ext_rdata_i (ext_rdata_i), .rdata_o (rdata_o),
        .busy_o (busy_o), .carry_o (carry_o), .cnt_clr_o (cnt_clr_o),
        .sel_cnt_o (sel_cnt_o), .sel_ctl_o (sel_ctl_o), .sel_ram_o (sel_ram_o),
        .cnt_we_o (cnt_we_o), .ram_we_o (ram_we_o), .ram_idx_o (ram_idx_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected busy level after n ticks (R3).
    function automatic int busy_exp(input int n);
        return ((n % TPS) >= TPS - LEAD) || (n > 0 && (n % TPS) == 0);
    endfunction

    // One write cycle on the parallel port.
    task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    // Present an address for reading, settle, return the read nibble.
    task automatic rd_reg(input logic [3:0] a, output int v);
        @(negedge clk);
        addr_i = a; wr_i = 1'b0;
        #1 v = rdata_o;
    endtask

    int v;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 carry", carry_o, 0);
        chk("R1 clr", cnt_clr_o, 0);
        rd_reg(4'hF, v); chk("R1 mode reg", v, 0);
        rd_reg(4'hE, v); chk("R1 status reg", v, 0);

        // R9 R10 R11 R6: decode sweep over all four field values and addresses
        for (int m = 0; m < 4; m++) begin
            wr_reg(4'hF, 4'(m));
            for (int a = 0; a < 16; a++) begin
                int e_cnt, e_ctl, e_ram, e_idx, e_rd;
                @(negedge clk);
                addr_i = 4'(a); ext_rdata_i = 4'(a ^ 5); wr_i = (a <= 13);
                #1;
                if (m < 2) begin
                    e_cnt = (a < 13); e_ctl = (a >= 13); e_ram = 0; e_idx = 0;
                    e_rd = (a == 15) ? m : (a == 14) ? 0 : (a ^ 5);
                end else begin
                    e_cnt = 0; e_ctl = (a == 15); e_ram = (a < 15);
                    e_idx = (a < 15) ? a + ((m == 3) ? HALF : 0) : 0;
                    e_rd = (a == 15) ? m : (a ^ 5);
                end
                chk("R9 sel_cnt", sel_cnt_o, e_cnt);
                chk("R9 sel_ctl", sel_ctl_o, e_ctl);
                chk("R10 sel_ram", sel_ram_o, e_ram);
                chk("R10 ram_idx", ram_idx_o, e_idx);
                chk("R11 rdata", rdata_o, e_rd);
                chk("R4 cnt_we idle", cnt_we_o, (a <= 13) && e_cnt);
                chk("R10 ram_we", ram_we_o, (a <= 13) && e_ram);
            end
            @(negedge clk) wr_i = 1'b0;
        end
        wr_reg(4'hF, 4'h0);

        // R2 R3 R4 R8: tick sweep with a counter write held on every tick
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            tick_i = 1'b1; addr_i = 4'h3; wr_i = 1'b1;
            #1 chk("R4 write before edge", cnt_we_o, !busy_exp(k - 1));
            @(posedge clk); #1;
            chk("R2 carry", carry_o, (k % TPS) == 0);
            chk("R3 busy", busy_o, busy_exp(k));
            chk("R4 write after edge", cnt_we_o, !busy_exp(k));
            wr_i = 1'b0; addr_i = 4'hE;
            #1 chk("R8 status busy bit", rdata_o, busy_exp(k) << 3);
            @(negedge clk);
            tick_i = 1'b0; addr_i = 4'h3;
            @(posedge clk); #1;
            chk("R2 carry one cycle", carry_o, 0);
        end

        // R5: power-on pulse sets the flag
        @(negedge clk) por_i = 1'b1;
        @(negedge clk) por_i = 1'b0;
        rd_reg(4'hE, v); chk("R5 por sets", v, 4'b0100);
        // R8: writes to the status address are ignored
        wr_reg(4'hE, 4'b1011);
        rd_reg(4'hE, v); chk("R8 status write ignored", v, 4'b0100);
        chk("R8 busy unchanged", busy_o, 0);

        // R5 R7: reset write clears the flag and raises the counter clear
        cs_i = 1'b0; sck_i = 1'b0;
        wr_reg(4'hF, 4'b1000);
        chk("R7 clr set", cnt_clr_o, 1);
        rd_reg(4'hE, v); chk("R5 cleared by reset write", v, 0);
        rd_reg(4'hF, v); chk("R6 mode reg readback", v, 4'b1000);
        @(negedge clk) begin cs_i = 1'b1; sck_i = 1'b1; end
        @(posedge clk); #1 chk("R7 hold with clock high", cnt_clr_o, 1);
        @(negedge clk) sck_i = 1'b0;
        @(posedge clk); #1 chk("R7 self clear", cnt_clr_o, 0);
        rd_reg(4'hF, v); chk("R7 readback after clear", v, 0);

        // R5: power-on pulse and reset write in one cycle
        @(negedge clk);
        cs_i = 1'b0; sck_i = 1'b0;
        por_i = 1'b1; addr_i = 4'hF; wdata_i = 4'b1000; wr_i = 1'b1;
        @(negedge clk); por_i = 1'b0; wr_i = 1'b0;
        rd_reg(4'hE, v); chk("R5 por wins", v, 4'b0100);
        chk("R7 clr from collided write", cnt_clr_o, 1);

        // R7: reset write with release condition present in the same cycle
        @(negedge clk) begin cs_i = 1'b1; sck_i = 1'b0; end
        @(posedge clk); #1 chk("R7 release", cnt_clr_o, 0);
        @(negedge clk); addr_i = 4'hF; wdata_i = 4'b1000; wr_i = 1'b1;
        @(posedge clk); #1 chk("R7 write wins", cnt_clr_o, 1);
        @(negedge clk) wr_i = 1'b0;
        @(posedge clk); #1 chk("R7 release next cycle", cnt_clr_o, 0);
        rd_reg(4'hE, v); chk("R5 cleared after collision", v, 0);

        // R6: test bit stored and read back in both RAM maps
        @(negedge clk) cs_i = 1'b0;
        wr_reg(4'hF, 4'b0110);
        rd_reg(4'hF, v); chk("R6 test in map 1", v, 4'b0110);
        wr_reg(4'hF, 4'b0111);
        rd_reg(4'hF, v); chk("R6 test in map 2", v, 4'b0111);
        chk("R7 no clear", cnt_clr_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule